// File: doc/BRIEF.md
# SPI Addressed Register Access Slave

This block sits on the slave side of a four-wire SPI link in mode 0 and turns each chip-select frame into reads or writes on a plain parallel register bus. Every frame starts with a one-byte header. Its top bit gives the direction (1 means read) and its low seven bits name the slave that is meant. A fixed number of address bytes follows, and after them comes either a stream of write data or a stream of filler bytes that pull read data back to the host. When the ID in the header does not match the block's own ID, the block stays silent for the rest of the frame. This lets several such blocks share one bus, each with its own ID.

The SPI pins are sampled by the system clock, which must run at least eight times faster than SCLK. The pins are taken to be synchronous to that clock already. In a read frame, the first data-phase byte the block sends back is a copy of the header. After that it returns one register byte per filler byte. The block fetches each byte over the bus one byte-time before it is needed, so the byte is ready in the MISO shift register before its first SCLK edge. The address steps by one after every data byte in both directions, and a frame may run for any length.

Top module: `spi_regbus_slave`

## Requirements
- R1: The first complete byte after spi_cs_n falls is the header. Bit 7 is the direction (1 = read, 0 = write) and bits 6:0 are the target ID.
- R2: If the header ID differs from the SLAVE_ID parameter, the block drives no reg_wr and no reg_rd for the rest of the frame, and MISO stays 0.
- R3: ADDR_BYTES address bytes follow the header, most significant first, and form the start address shown on reg_addr with the first data access. No bus strobe occurs before the header and all address bytes have been received.
- R4: In a write frame, each full byte after the address produces exactly one single-cycle reg_wr carrying that byte on reg_wdata. The number of data bytes is unbounded.
- R5: reg_addr increases by one in the cycle after every reg_wr or reg_rd strobe, so a burst covers consecutive addresses (carrying across byte boundaries).
- R6: In a read frame, the first byte on MISO after the address phase equals the header byte. The next bytes are the register contents at the start address, start+1, and so on. N data bytes therefore take N+1 filler bytes.
- R7: The values of filler bytes in a read frame do not affect the returned data.
- R8: Raising spi_cs_n at any point ends the frame. A partial byte is discarded, the decoder returns to waiting for a header, and no strobe results from that partial byte.
- R9: The interface is SPI mode 0 with MSB first. MOSI is taken on SCLK rising edges, and MISO changes only after SCLK falling edges while chip select is low.
- R10: MISO is 0 while spi_cs_n is high, during the header and address phase, and throughout write frames.
- R11: reg_wr and reg_rd are never high together, and each is a single-cycle pulse.
- R12: A read frame issues one reg_rd when its last address byte completes, plus one reg_rd after each filler byte. reg_rdata is taken one clock after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | 8*ADDR_BYTES | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_rd |

## Verification
Some properties hold on every cycle, and the assertions check those: the strobes are exclusive and last one cycle, the address steps after each strobe, no access comes before the header and address have been clocked in, MISO moves only after a falling SCLK edge, and MISO is quiet outside a frame. Other behaviour depends on the content of a whole frame, and only the bench's scenarios can show it. This covers ID filtering, the header echo, the order of the returned data, filler independence, address carry across a byte boundary, the number of prefetch reads, and recovery after chip select is dropped in the middle of the address or data phase.

// File: rtl/spi_regbus_pkg.sv
// Shared types for the SPI register access slave.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package spi_regbus_pkg;

    // Frame decoder phases within one chip-select frame.
    typedef enum logic [2:0] {
        PH_HEADER,   // waiting for direction/ID byte
        PH_ADDRESS,  // collecting address bytes
        PH_WRITE,    // every byte is write data
        PH_READ,     // every byte is a filler; data goes out on MISO
        PH_SKIP      // ID mismatch: ignore until chip select rises
    } frame_phase_e;

endpackage

// File: rtl/spi_m0_shifter.sv
// Mode-0 SPI byte shifter. SCLK is oversampled by clk; the SPI pins are
// assumed synchronous to clk and SCLK at most clk/8. Collects MOSI bits on
// rising SCLK (MSB first) and pulses rx_valid for one clk per full byte.
// MISO shifts on falling SCLK; at the falling edge that closes a byte the
// register reloads from tx_next. Chip select high clears all state.
module spi_m0_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    input  logic [DW-1:0] tx_next,
    output logic          miso,
    output logic          rx_valid,
    output logic [DW-1:0] rx_byte
);
    localparam int CNT_W = (DW > 2) ? $clog2(DW) : 1;

    logic             sclk_d;
    logic             sclk_rise;
    logic             sclk_fall;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    rx_sr;
    logic [DW-1:0]    tx_sr;

    assign sclk_rise = sclk & ~sclk_d & ~cs_n;
    assign sclk_fall = ~sclk & sclk_d & ~cs_n;
    assign miso      = tx_sr[DW-1];

    // Delay SCLK by one clk for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk;
    end

    // Receive path: shift on rising SCLK, flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (sclk_rise) begin
                rx_sr <= {rx_sr[DW-2:0], mosi};
                if (bit_cnt == CNT_W'(DW-1)) begin
                    bit_cnt  <= '0;
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sr[DW-2:0], mosi};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Transmit path: reload at byte boundary, otherwise shift on falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            tx_sr <= '0;
        end else if (sclk_fall) begin
            if (bit_cnt == '0) tx_sr <= tx_next;
            else               tx_sr <= {tx_sr[DW-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_frame_decoder.sv
// Frame decoder: reads the header byte, gathers ADDR_BYTES address bytes
// (MSB first), then issues write strobes per data byte or read strobes per
// filler byte. Read data is fetched one byte ahead and presented on tx_next
// before the shifter's next byte boundary. Assumes rd_data is valid one clk
// after bus_rd and that rx_valid pulses are many clks apart.
module spi_frame_decoder
    import spi_regbus_pkg::*;
#(
    parameter logic [6:0] SLAVE_ID   = 7'h2A,
    parameter int         ADDR_BYTES = 2,
    parameter int         AW         = 8 * ADDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic [7:0]    rd_data,
    output logic [7:0]    tx_next,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          bus_wr,
    output logic          bus_rd
);
    localparam int ACW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    frame_phase_e   phase;
    logic [7:0]     hdr_q;
    logic [ACW-1:0] abyte_cnt;
    logic [AW-1:0]  addr_q;
    logic [AW-1:0]  addr_shift;
    logic           id_hit;
    logic           last_abyte;
    logic           rd_pend;
    logic [7:0]     rd_buf;

    assign id_hit     = (rx_byte[6:0] == SLAVE_ID);
    assign last_abyte = (abyte_cnt == ACW'(ADDR_BYTES - 1));
    assign bus_addr   = addr_q;

    // Shift the incoming byte into the low end of the address.
    generate
        if (ADDR_BYTES == 1) begin : g_addr_one
            assign addr_shift = rx_byte;
        end else begin : g_addr_many
            assign addr_shift = {addr_q[AW-9:0], rx_byte};
        end
    endgenerate

    // Phase sequencing across the bytes of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            phase     <= PH_HEADER;
            hdr_q     <= '0;
            abyte_cnt <= '0;
        end else if (rx_valid) begin
            case (phase)
                PH_HEADER: begin
                    hdr_q     <= rx_byte;
                    abyte_cnt <= '0;
                    phase     <= id_hit ? PH_ADDRESS : PH_SKIP;
                end
                PH_ADDRESS: begin
                    if (last_abyte) phase <= hdr_q[7] ? PH_READ : PH_WRITE;
                    else            abyte_cnt <= abyte_cnt + 1'b1;
                end
                default: phase <= phase;
            endcase
        end
    end

    // Bus strobes, write data and the next MISO byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
            bus_wdata <= '0;
            tx_next   <= '0;
        end else begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
            if (cs_n) begin
                tx_next <= '0;
            end else if (rx_valid) begin
                case (phase)
                    PH_ADDRESS: begin
                        if (last_abyte && hdr_q[7]) begin
                            tx_next <= hdr_q;
                            bus_rd  <= 1'b1;
                        end
                    end
                    PH_WRITE: begin
                        bus_wdata <= rx_byte;
                        bus_wr    <= 1'b1;
                    end
                    PH_READ: begin
                        tx_next <= rd_buf;
                        bus_rd  <= 1'b1;
                    end
                    default: tx_next <= tx_next;
                endcase
            end
        end
    end

    // Address: load from address bytes, step after every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                                addr_q <= '0;
        else if (bus_wr || bus_rd)                 addr_q <= addr_q + 1'b1;
        else if (rx_valid && !cs_n && phase == PH_ADDRESS) addr_q <= addr_shift;
    end

    // Capture read data one clk after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_buf  <= '0;
        end else begin
            rd_pend <= bus_rd;
            if (rd_pend) rd_buf <= rd_data;
        end
    end

endmodule

// File: rtl/spi_regbus_slave.sv
// Top: SPI mode-0 slave carrying header/address/data frames onto a parallel
// register bus. Assumes SPI pins synchronous to clk and SCLK <= clk/8.
module spi_regbus_slave #(
    parameter logic [6:0] SLAVE_ID   = 7'h2A,
    parameter int         ADDR_BYTES = 2,
    localparam int        AW         = 8 * ADDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sclk,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic [AW-1:0] reg_addr,
    output logic [7:0]    reg_wdata,
    output logic          reg_wr,
    output logic          reg_rd,
    input  logic [7:0]    reg_rdata
);
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic [7:0] tx_next;

    spi_m0_shifter #(.DW(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .tx_next  (tx_next),
        .miso     (spi_miso),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    spi_frame_decoder #(
        .SLAVE_ID   (SLAVE_ID),
        .ADDR_BYTES (ADDR_BYTES),
        .AW         (AW)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rd_data   (reg_rdata),
        .tx_next   (tx_next),
        .bus_addr  (reg_addr),
        .bus_wdata (reg_wdata),
        .bus_wr    (reg_wr),
        .bus_rd    (reg_rd)
    );

endmodule

// File: rtl/spi_regbus_checker.sv
// Protocol checker for spi_regbus_slave, attached by bind below. Watches
// the SPI pins and register bus only; keeps its own SCLK rise counter.
module spi_regbus_checker #(
    parameter int ADDR_BYTES = 2,
    parameter int AW         = 8 * ADDR_BYTES
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_sclk,
    input logic          spi_cs_n,
    input logic          spi_miso,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic          reg_rd
);
    localparam logic [15:0] MIN_RISES = 16'(8 * (1 + ADDR_BYTES));

    logic        sclk_p;
    logic [15:0] rise_cnt;

    // Count SCLK rising edges inside the current frame (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_p <= spi_sclk;
            if (spi_cs_n)                                       rise_cnt <= '0;
            else if (spi_sclk && !sclk_p && rise_cnt != 16'hFFFF) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R11: strobes exclusive
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    // R11: write strobe is one cycle
    a_r11_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    // R11: read strobe is one cycle
    a_r11_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    // R5: address steps after each strobe
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |=> (reg_addr == $past(reg_addr) + 1'b1));
    // R3: no access before header and address bytes
    a_r3_no_early_access: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> (rise_cnt >= MIN_RISES));
    // R9: MISO moves only after a falling SCLK edge in a frame
    a_r9_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(spi_miso) && !$past(spi_cs_n)) |-> ($past(spi_sclk, 2) && !$past(spi_sclk)));
    // R10: MISO quiet when not selected
    a_r10_idle_miso: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_cs_n) |-> !spi_miso);

endmodule

bind spi_regbus_slave spi_regbus_checker #(
    .ADDR_BYTES (ADDR_BYTES),
    .AW         (AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd)
);

// File: tb/sim_spi_regbus_slave.sv
`timescale 1ns/1ps
module sim_spi_regbus_slave;
    localparam logic [6:0] MY_ID = 7'h2A;
    localparam int         NAB   = 2;
    localparam int         HALF  = 8;
    localparam int         NVEC  = 7;
    // {dir,id}[47:40] addr[39:24] len[23:16] seed[15:8] step_or_filler[7:0]
    localparam logic [47:0] VEC [NVEC] = '{
        48'h2A_0010_04_11_22,   // write, match
        48'hAA_0010_04_00_00,   // read, filler 00
        48'hAA_0010_04_00_FF,   // read, filler FF (R7)
        48'h15_0010_03_99_01,   // write, wrong ID
        48'h95_0020_02_00_00,   // read, wrong ID
        48'h2A_00FE_05_40_03,   // write across byte carry
        48'hAA_00FE_05_00_A5    // read across byte carry
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [7:0]  reg_rdata;

    logic [7:0]  mem [1024];
    logic [7:0]  exp_mem [1024];
    int          wr_seen = 0;
    int          rd_seen = 0;
    int          addr_bad = 0;
    logic [15:0] exp_wr_addr = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    spi_regbus_slave #(.SLAVE_ID(MY_ID), .ADDR_BYTES(NAB)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata)
    );

    // Register memory model with one-cycle read latency and write-address monitor.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'(i * 7 + 3);
            reg_rdata <= '0;
        end else begin
            if (reg_wr) begin
                mem[reg_addr[9:0]] <= reg_wdata;
                wr_seen <= wr_seen + 1;
                if (reg_addr != exp_wr_addr) addr_bad <= addr_bad + 1;
                exp_wr_addr <= exp_wr_addr + 1'b1;
            end
            if (reg_rd) begin
                reg_rdata <= mem[reg_addr[9:0]];
                rd_seen   <= rd_seen + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift nbits of tx (MSB first) in mode 0; MISO captured before each rise.
    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b > 7 - nbits; b--) begin
            mosi = tx[b];
            wait_clk(HALF);
            rx[b] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic frame_start;
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic frame_end;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        logic [7:0] rxv [10];
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'(i * 7 + 3);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // Reset state
        check(miso == 1'b0, "R10 reset miso", miso, 0);
        check(!reg_wr && !reg_rd, "R11 reset strobes", {reg_wr, reg_rd}, 0);
        check(reg_addr == 16'h0, "R3 reset addr", reg_addr, 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0]  hdr;
            logic [15:0] a;
            int          len;
            logic [7:0]  seed, step;
            bit          hit, rnw, miso_zero;
            int          wr0, rd0;
            hdr  = VEC[v][47:40];
            a    = VEC[v][39:24];
            len  = int'(VEC[v][23:16]);
            seed = VEC[v][15:8];
            step = VEC[v][7:0];
            rnw  = hdr[7];
            hit  = (hdr[6:0] == MY_ID);
            wr0  = wr_seen;
            rd0  = rd_seen;
            exp_wr_addr = a;
            miso_zero = 1'b1;
            frame_start();
            xfer(hdr, 8, rx);        miso_zero &= (rx == 8'h00);
            xfer(a[15:8], 8, rx);    miso_zero &= (rx == 8'h00);
            xfer(a[7:0], 8, rx);     miso_zero &= (rx == 8'h00);
            if (!rnw) begin
                for (int i = 0; i < len; i++) begin
                    logic [7:0] d;
                    d = 8'(seed + 8'(i) * step);
                    if (hit) exp_mem[10'(a + 16'(i))] = d;
                    xfer(d, 8, rx);
                    miso_zero &= (rx == 8'h00);
                end
            end else begin
                for (int i = 0; i <= len; i++) begin
                    xfer(step, 8, rx);
                    rxv[i] = rx;
                    miso_zero &= (rx == 8'h00);
                end
            end
            frame_end();
            wait_clk(4);
            if (!rnw && hit) begin
                check(wr_seen - wr0 == len, "R4 write strobe count", wr_seen - wr0, len);
                check(addr_bad == 0, "R3/R5 write addresses", addr_bad, 0);
                for (int i = 0; i < len; i++)
                    check(mem[10'(a + 16'(i))] == exp_mem[10'(a + 16'(i))], "R4 R5 written byte",
                          mem[10'(a + 16'(i))], exp_mem[10'(a + 16'(i))]);
                check(miso_zero, "R10 miso zero in write", miso_zero, 1);
            end else if (rnw && hit) begin
                check(rxv[0] == hdr, "R6 header echo", rxv[0], hdr);
                for (int i = 0; i < len; i++)
                    check(rxv[i+1] == exp_mem[10'(a + 16'(i))], "R6 R7 read byte",
                          rxv[i+1], exp_mem[10'(a + 16'(i))]);
                check(rd_seen - rd0 == len + 2, "R12 prefetch read count", rd_seen - rd0, len + 2);
                check(wr_seen == wr0, "R1 read issues no write", wr_seen - wr0, 0);
            end else begin
                check(wr_seen == wr0 && rd_seen == rd0, "R2 foreign ID strobes",
                      (wr_seen - wr0) + (rd_seen - rd0), 0);
                check(miso_zero, "R2 R10 foreign ID miso", miso_zero, 1);
                check(mem[10'(a)] == exp_mem[10'(a)], "R2 memory untouched", mem[10'(a)], exp_mem[10'(a)]);
            end
        end

        // R8: abort inside the address phase, then a clean write
        begin
            int wr0;
            wr0 = wr_seen;
            frame_start();
            xfer(8'h2A, 8, rx);
            xfer(8'h00, 8, rx);
            xfer(8'hFF, 3, rx);
            frame_end();
            check(wr_seen == wr0, "R8 abort in address no strobe", wr_seen - wr0, 0);
            exp_wr_addr = 16'h0040;
            frame_start();
            xfer(8'h2A, 8, rx);
            xfer(8'h00, 8, rx);
            xfer(8'h40, 8, rx);
            xfer(8'h77, 8, rx);
            frame_end();
            wait_clk(4);
            check(wr_seen - wr0 == 1, "R8 recovery write count", wr_seen - wr0, 1);
            check(mem[10'h040] == 8'h77, "R8 recovery write data", mem[10'h040], 8'h77);
            check(addr_bad == 0, "R8 recovery write address", addr_bad, 0);
        end

        // R8: abort inside a data byte
        begin
            int wr0;
            logic [7:0] keep;
            wr0 = wr_seen;
            keep = mem[10'h051];
            exp_wr_addr = 16'h0050;
            frame_start();
            xfer(8'h2A, 8, rx);
            xfer(8'h00, 8, rx);
            xfer(8'h50, 8, rx);
            xfer(8'h12, 8, rx);
            xfer(8'hFF, 5, rx);
            frame_end();
            wait_clk(4);
            check(wr_seen - wr0 == 1, "R8 partial byte dropped", wr_seen - wr0, 1);
            check(mem[10'h050] == 8'h12, "R8 full byte written", mem[10'h050], 8'h12);
            check(mem[10'h051] == keep, "R8 next address untouched", mem[10'h051], keep);
            check(miso == 1'b0 && !reg_wr && !reg_rd, "R10 R11 idle after abort",
                  {miso, reg_wr, reg_rd}, 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule